// File: doc/BRIEF.md
# Cascadable Serial-Load Channel Driver Control

This block is the digital control path of an LED sink driver that drives eight channels per device. A serial bit stream is clocked into a shift chain on every rising edge of the shift clock. The chain is built from one or more eight-stage device slices; the parameter `NUM_DEV` sets how many. The last stage of the last slice is brought out as a serial output, so further blocks can be chained behind it. A level-sensitive hold latch sits between the shift chain and the channels. It is transparent while the strobe input is high and keeps its contents while the strobe is low. An active-low output enable gates the latched bits onto the channel-on requests.

Typically a controller shifts a full frame of `8*NUM_DEV` bits with the strobe low, so the lit pattern does not flicker. It then pulses the strobe to update every channel at once. It drives the enable high to blank all channels, for example for brightness modulation. The outputs are logic on/off requests only; current regulation lives elsewhere.

Top module: `led_sink_ctrl`

## Requirements
- R1: On each rising edge of `clk`, the bit on `sdi` enters the first stage, which drives channel 0 of device 0 (`chan_on[0]`).
- R2: Flat channel index `j = 8*d + k` (device `d`, channel `k`) holds the bit that was shifted in `j` rising edges before the newest bit. Higher indices hold older data.
- R3: `sdo` carries the bit that was applied on `sdi` exactly `8*NUM_DEV` rising edges earlier, or 0 if fewer edges have occurred since reset.
- R4: While `strobe` is 1, the latch is transparent. A rising clock edge or a rising strobe shows the current chain contents on the channels in the same cycle, with no extra clock.
- R5: While `strobe` is 0, the latched contents and the channel outputs are held, even while shifting continues.
- R6: When `oe_n` is 1, every bit of `chan_on` is 0 at once, whatever the latch holds. When `oe_n` is 0, `chan_on[j]` equals latched bit `j`, and 1 means the channel is on.
- R7: A falling edge of `clk` changes neither the chain, `sdo` nor the channels.
- R8: Asserting `rst_n` low clears the shift chain and the latch at once. `sdo` and all of `chan_on` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| sdi | input | 1 | Serial data into the first stage |
| strobe | input | 1 | Latch transparent while high, holds while low |
| oe_n | input | 1 | Active-low output enable; high forces all channels off |
| sdo | output | 1 | Last stage of the last device, for chaining |
| chan_on | output | 8*NUM_DEV | Channel on requests, index 8*device+channel |

## Verification
A rising clock edge with the strobe high changes the shift chain and the channel outputs in the same cycle. The bench therefore shifts a long parity-derived stream with the strobe held high and the enable low. About 1 ns after each edge it compares the whole channel vector and `sdo` against values it computes from its own record of every bit sent. Shifting and blanking also overlap: the enable is raised and lowered during a shift run, and the channels must read all-off at once and then return to the new chain contents. Holding is checked by shifting twenty bits with the strobe low, then raising the strobe between edges and expecting the pending frame to appear without a clock.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;
  localparam int unsigned LANES = 8;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/led_shift_slice.sv
module led_shift_slice
  import led_sink_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output lane_vec_t q,
  output logic      dout
);
  lane_vec_t q_nxt;

  always_comb begin
    q_nxt = {q[LANES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign dout = q[LANES-1];

  // R1: newest bit lands in stage 0
  a_r1_stage0_takes_din: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q[0] == $past(din));

  // R2: each stage takes the previous content of its neighbour
  a_r2_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q[LANES-1:1] == $past(q[LANES-2:0]));
endmodule

// File: rtl/led_hold_latch.sv
module led_hold_latch
  import led_sink_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  lane_vec_t d,
  output lane_vec_t q
);
  always_latch begin
    if (!rst_n)      q = '0;
    else if (strobe) q = d;
  end

  // R4: transparent while strobe is high
  a_r4_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> q == d);

  // R5: contents held while strobe stays low
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !strobe && !$past(strobe)) |-> $stable(q));
endmodule

// File: rtl/led_out_gate.sv
module led_out_gate
  import led_sink_pkg::*;
(
  input  logic      oe_n,
  input  lane_vec_t lat,
  output lane_vec_t ch
);
  always_comb begin
    ch = oe_n ? '0 : lat;
  end
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
  import led_sink_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sdi,
  input  logic                     strobe,
  input  logic                     oe_n,
  output logic                     sdo,
  output logic [LANES*NUM_DEV-1:0] chan_on
);
  localparam int unsigned TOTAL = LANES * NUM_DEV;

  logic [NUM_DEV:0]   link;
  logic [TOTAL-1:0]   chain_q;
  logic [TOTAL-1:0]   lat_q;

  assign link[0] = sdi;

  for (genvar dv = 0; dv < NUM_DEV; dv++) begin : g_dev
    lane_vec_t sh_q;
    lane_vec_t hl_q;
    lane_vec_t gt_q;

    led_shift_slice u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (link[dv]),
      .q    (sh_q),
      .dout (link[dv+1])
    );

    led_hold_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(strobe),
      .d     (sh_q),
      .q     (hl_q)
    );

    led_out_gate u_gate (
      .oe_n(oe_n),
      .lat (hl_q),
      .ch  (gt_q)
    );

    assign chain_q[dv*LANES +: LANES] = sh_q;
    assign lat_q[dv*LANES +: LANES]   = hl_q;
    assign chan_on[dv*LANES +: LANES] = gt_q;
  end

  assign sdo = link[NUM_DEV];

  // R3: serial output is the previous content of the second-to-last stage
  a_r3_sdo_from_chain: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sdo == $past(chain_q[TOTAL-2]));

  // R6: enable high blanks every channel
  a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> chan_on == '0);

  // R6: enable low shows latched bits
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> chan_on == lat_q);
endmodule

// File: tb/led_sink_ctrl_test.sv
`timescale 1ns/1ps
module led_sink_ctrl_test;
  localparam int NDEV = 2;
  localparam int W    = 8 * NDEV;

  logic         clk = 1'b0;
  logic         rst_n, sdi, strobe, oe_n;
  logic         sdo;
  logic [W-1:0] chan_on;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  hist [0:8191];
  int  nsh = 0;
  logic [W-1:0] lat_m;
  bit  done = 0;

  always #2.5 clk = ~clk;

  led_sink_ctrl #(.NUM_DEV(NDEV)) uut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .strobe(strobe),
    .oe_n(oe_n), .sdo(sdo), .chan_on(chan_on)
  );

  function automatic logic [W-1:0] chain_exp();
    logic [W-1:0] v = '0;
    for (int j = 0; j < W; j++)
      if (nsh - 1 - j >= 0) v[j] = hist[nsh-1-j];
    return v;
  endfunction

  function automatic logic sdo_exp();
    return (nsh >= W) ? hist[nsh-W] : 1'b0;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift1(bit b);
    sdi = b;
    @(posedge clk);
    #1;
    hist[nsh] = b;
    nsh++;
    if (strobe) lat_m = chain_exp();
  endtask

  function automatic logic [W-1:0] out_exp();
    return oe_n ? '0 : lat_m;
  endfunction

  initial begin
    rst_n = 1'b0; sdi = 1'b0; strobe = 1'b0; oe_n = 1'b0;
    lat_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset channels", chan_on, '0);
    chk("R8 reset sdo", {{(W-1){1'b0}}, sdo}, '0);
    rst_n = 1'b1;

    // transparent sweep: R1 R2 R3 R4
    strobe = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      shift1(^(i[11:0] & 12'h2d5) ^ i[0]);
      chk("R1 R2 R4 channels follow chain", chan_on, chain_exp());
      chk("R3 sdo delay", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, sdo_exp()});
      if (i % 97 == 5) begin
        @(negedge clk); #1;
        chk("R7 falling edge no change", chan_on, chain_exp());
        chk("R7 falling edge sdo", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, sdo_exp()});
      end
    end

    // hold with strobe low: R5
    strobe = 1'b0;
    #1;
    for (int i = 0; i < 20; i++) begin
      shift1(i[0] ^ i[2]);
      chk("R5 hold while strobe low", chan_on, out_exp());
      chk("R3 sdo during hold", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, sdo_exp()});
    end
    strobe = 1'b1;
    #0.5;
    lat_m = chain_exp();
    chk("R4 strobe rise shows frame", chan_on, lat_m);

    // blanking within a shift run: R6
    for (int i = 0; i < 40; i++) begin
      shift1(i[1]);
      if (i == 10) begin oe_n = 1'b1; #0.5; chk("R6 blank immediate", chan_on, '0); end
      if (i == 25) begin oe_n = 1'b0; #0.5; chk("R6 restore immediate", chan_on, lat_m); end
      chk("R6 gated outputs", chan_on, out_exp());
    end

    // all-ones frame then async reset: R8
    for (int i = 0; i < W; i++) shift1(1'b1);
    chk("R6 all on", chan_on, {W{1'b1}});
    #0.7;
    rst_n = 1'b0;
    #0.5;
    chk("R8 async clear channels", chan_on, '0);
    chk("R8 async clear sdo", {{(W-1){1'b0}}, sdo}, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    nsh = 0;
    lat_m = '0;
    shift1(1'b1);
    chk("R1 first bit after reset", chan_on, {{(W-1){1'b0}}, 1'b1});
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule